// File: doc/BRIEF.md
# Quarter-Rate Carrier Mixer

This block places an interleaved stream of pulse-shaped in-phase and quadrature samples onto a carrier whose frequency is exactly one quarter of the output sample rate. At that ratio the cosine and sine of the carrier only take the values +1, 0 and -1. Every output slot therefore reduces to passing one of the two components, either unchanged or negated. No multiplier and no adder are needed.

Each symbol spans four output slots. A two-bit slot counter steps through them in a fixed order: +I, +Q, -I, -Q. A symbol strobe that arrives with a sample forces that sample into the first slot. Each accepted sample carries a tag that says whether it is an I or a Q value. A sample whose tag does not fit its slot latches a sticky error flag. The signed result is cut to its most significant bits and held in a register that drives a DAC directly.

Top module: `quarter_rate_mixer`

## Requirements
- R1: During and right after reset, `dac_word` is 0, `dac_valid` is 0 and `tag_err` is 0.
- R2: An accepted sample in slot 0 or slot 1 appears unchanged on `dac_word` in the next cycle. `dac_word` holds the upper DW bits of the W-bit signed sample, truncated and not rounded.
- R3: An accepted sample in slot 2 or slot 3 appears two's-complement negated in the next cycle, in the same DW-bit truncated form.
- R4: Negating the most negative sample gives the most positive W-bit value. With the defaults (W=12, DW=10), -2048 in a negating slot drives `dac_word` = 0x1FF (+511).
- R5: Each accepted sample advances the slot by one, modulo 4. An accepted sample with `sym_strobe` high is placed in slot 0, whatever slot was pending.
- R6: The expected tag is `in_is_q`=0 (I) in slots 0 and 2 and `in_is_q`=1 (Q) in slots 1 and 3. A mismatch on an accepted sample sets `tag_err` in the next cycle, and it stays set until reset.
- R7: In a cycle with `in_valid` low, `dac_word`, the pending slot and `tag_err` keep their values, and `sym_strobe`, `in_is_q` and `in_sample` have no effect.
- R8: `dac_valid` equals `in_valid` delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one output slot per accepted sample |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A filtered sample is present this cycle |
| sym_strobe | input | 1 | This sample opens a new symbol (slot 0) |
| in_is_q | input | 1 | Tag: 0 = I sample, 1 = Q sample |
| in_sample | input | W (12) | Signed filtered sample |
| dac_word | output | DW (10) | Registered signed DAC drive word |
| dac_valid | output | 1 | `dac_word` was updated in the previous edge |
| tag_err | output | 1 | Sticky tag-mismatch flag |

## Verification
The bound checker monitors several properties on every cycle:
- valid tracking (R8);
- holding during gaps (R7);
- stickiness of the error flag (R6);
- pass-through at a strobed slot (R2);
- the saturation case (R4), which it finds with its own slot tracker.

Some behaviour only the bench's scenarios show. These are the full +I, +Q, -I, -Q pattern over long runs, a strobe that restarts a symbol in mid-flight, a continuation with no strobe, and a strobe asserted during an idle cycle. For these, the bench compares the outputs on every clock against a behavioural model.

// File: rtl/quarter_rate_mixer.sv
module quarter_rate_mixer #(
  parameter int W  = 12,
  parameter int DW = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                sym_strobe,
  input  logic                in_is_q,
  input  logic signed [W-1:0] in_sample,
  output logic [DW-1:0]       dac_word,
  output logic                dac_valid,
  output logic                tag_err
);
  localparam logic signed [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [1:0] phase;
  logic [1:0] slot;
  logic signed [W-1:0] neg_val;
  logic signed [W-1:0] mixed;

  assign slot    = sym_strobe ? 2'd0 : phase;
  assign neg_val = (in_sample == SMIN) ? SMAX : -in_sample;
  assign mixed   = slot[1] ? neg_val : in_sample;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= 2'd0;
      dac_word  <= '0;
      dac_valid <= 1'b0;
      tag_err   <= 1'b0;
    end else begin
      dac_valid <= in_valid;
      if (in_valid) begin
        phase    <= slot + 2'd1;
        dac_word <= mixed[W-1 -: DW];
        if (in_is_q != slot[0]) tag_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/quarter_rate_mixer_chk.sv
module quarter_rate_mixer_chk #(
  parameter int W  = 12,
  parameter int DW = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                sym_strobe,
  input logic                in_is_q,
  input logic signed [W-1:0] in_sample,
  input logic [DW-1:0]       dac_word,
  input logic                dac_valid,
  input logic                tag_err
);
  localparam logic signed [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [DW-1:0] TOP = {1'b0, {(DW-1){1'b1}}};

  logic [1:0] slot_c;
  logic [1:0] cur;
  assign cur = sym_strobe ? 2'd0 : slot_c;

  always_ff @(posedge clk) begin
    if (!rst_n) slot_c <= 2'd0;
    else if (in_valid) slot_c <= cur + 2'd1;
  end

  a_r8_valid_rise: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> dac_valid);
  a_r8_valid_low:  assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !dac_valid);
  a_r7_hold_word:  assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(dac_word));
  a_r6_sticky:     assert property (@(posedge clk) disable iff (!rst_n) tag_err |=> tag_err);
  a_r6_strobe_q:   assert property (@(posedge clk) disable iff (!rst_n)
                     (in_valid && sym_strobe && in_is_q) |=> tag_err);
  a_r2_strobe_pass: assert property (@(posedge clk) disable iff (!rst_n)
                     (in_valid && sym_strobe) |=> (dac_word == $past(in_sample[W-1 -: DW])));
  a_r4_saturate:   assert property (@(posedge clk) disable iff (!rst_n)
                     (in_valid && cur[1] && in_sample == SMIN) |=> (dac_word == TOP));
endmodule

bind quarter_rate_mixer quarter_rate_mixer_chk #(.W(W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sym_strobe(sym_strobe),
  .in_is_q(in_is_q), .in_sample(in_sample), .dac_word(dac_word),
  .dac_valid(dac_valid), .tag_err(tag_err)
);

// File: tb/tb_quarter_rate_mixer.sv
module tb_quarter_rate_mixer;
  localparam int W  = 12;
  localparam int DW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, sym_strobe = 1'b0, in_is_q = 1'b0;
  logic signed [W-1:0] in_sample = '0;
  logic [DW-1:0] dac_word;
  logic dac_valid, tag_err;

  always #5 clk = ~clk;

  quarter_rate_mixer #(.W(W), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sym_strobe(sym_strobe),
    .in_is_q(in_is_q), .in_sample(in_sample), .dac_word(dac_word),
    .dac_valid(dac_valid), .tag_err(tag_err)
  );

  int total = 0, bad = 0;
  bit done = 0;
  int m_ph = 0, m_dac = 0;
  bit m_v = 0, m_err = 0;
  string m_req = "R1";

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic signed [DW-1:0] sd;
    sd = dac_word;
    chk(m_req, "dac_word", int'(sd), m_dac);
    chk("R8", "dac_valid", int'(dac_valid), int'(m_v));
    chk("R6", "tag_err", int'(tag_err), int'(m_err));
  endtask

  task automatic step(input bit v, input bit s, input bit q, input int smp);
    int eff, val;
    in_valid = v; sym_strobe = s; in_is_q = q; in_sample = W'(smp);
    m_v = v;
    if (!v) m_req = "R7";
    else begin
      eff = s ? 0 : m_ph;
      val = (eff >= 2) ? -smp : smp;
      if (val > (1 << (W-1)) - 1) begin val = (1 << (W-1)) - 1; m_req = "R4"; end
      else if (!s && eff != 0) m_req = (eff >= 2) ? "R5/R3" : "R5";
      else m_req = (eff >= 2) ? "R3" : "R2";
      m_dac = val >>> (W - DW);
      if (int'(q) != eff % 2) m_err = 1;
      m_ph = (eff + 1) % 4;
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 0; sym_strobe = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    m_ph = 0; m_dac = 0; m_v = 0; m_err = 0;
    chk("R1", "dac_word", int'(dac_word), 0);
    chk("R1", "dac_valid", int'(dac_valid), 0);
    chk("R1", "tag_err", int'(tag_err), 0);
    rst_n = 1'b1;
  endtask

  task automatic symbol(input int i0, input int q0, input int i1, input int q1);
    step(1, 1, 0, i0); step(1, 0, 1, q0); step(1, 0, 0, i1); step(1, 0, 1, q1);
  endtask

  initial begin
    do_reset();
    // R2 R3: basic symbols with assorted values
    symbol(100, -200, 300, -400);
    symbol(2047, 2047, 2047, 2047);
    symbol(-1, 5, 7, -3);
    // R4: most negative value in negating slots
    symbol(-2048, -2048, -2048, -2048);
    // R7: idle cycles with junk and strobe, pattern must resume
    step(1, 1, 0, 512);
    step(0, 1, 1, -2048);
    step(0, 1, 0, 999);
    step(1, 0, 1, 640);
    step(1, 0, 0, 640);
    step(0, 0, 1, 3);
    step(1, 0, 1, -640);
    // R5: continuation without strobe, then strobe mid-symbol
    step(1, 0, 0, 1000); step(1, 0, 1, -1000); step(1, 0, 0, 1234);
    step(1, 1, 0, 44);  step(1, 0, 1, -44);  step(1, 0, 0, 88); step(1, 0, 1, -2048);
    // longer pseudo-random stream with correct tags
    for (int k = 0; k < 200; k++) begin
      int val;
      val = ((k * 733 + 91) % 4096) - 2048;
      if (k % 4 == 0) step(1, 1, 0, val);
      else step(1, 0, (k % 4) % 2, val);
      if (k % 17 == 0) step(0, 0, 0, 0);
    end
    // R6: mismatched tag, sticky afterwards
    step(1, 1, 1, 10);
    step(1, 0, 1, 20);
    step(0, 0, 0, 0);
    symbol(1, 2, 3, 4);
    do_reset();
    symbol(8, 16, 24, 32);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule